// File: doc/BRIEF.md
# Indirect SDRAM Configuration Register File

This block is the software-visible configuration side of an SDRAM memory controller. Software reaches it through two locations on a simple register bus. A write to the first location stores a sub-register offset. A read or write at the second location then reaches the sub-register that the stored offset selects. The sub-registers are:

- two bus error status words and a bus error address
- a global control word and a read-only status word
- refresh and power-management timer words
- a timing word and an ECC configuration word
- an ECC error status word
- one control word per memory bank

Each bank control word holds a valid bit, a base address and a size code. From these the block decodes every physical address into per-bank hit flags and a one-hot bank select. A bank decodes only while the global enable bit of the control word is set. A rising or falling edge of that bit updates the status word. A nonzero ECC error status drives an interrupt line.

Reads return data one cycle after the request, marked by a valid strobe. DRAM command sequencing, the refresh engine and the data path are not part of this block.

Top module: `memcfg_indirect_regs`

## Requirements
- R1: After reset, the sub-registers hold these values: control 0x00800000, power timer 0x07C00000, refresh timer 0x05F00000. The offset latch and every other readable sub-register hold zero. The interrupt is low and no bank hits.
- R2: A bus write to address 0x10 stores the full 32-bit offset, and a bus read there returns it. A bus read or write at address 0x11 reaches the sub-register that the offset selects. A bus read at any other address returns zero. Read data appears with `rd_valid` in the cycle after the read request, and `rd_valid` is low in every cycle that does not follow a read.
- R3: The bus error status words at offsets 0x00 and 0x08 clear every bit that is written as one and never set bits from a write. The bus error address at offset 0x10 stores all 32 written bits.
- R4: Four sub-registers store a masked form of the written word. Refresh timer (0x30): the write AND 0x3FF80000. Power timer (0x34): (the write AND 0xF8000000) OR 0x07C00000. ECC configuration (0x94): the write AND 0x00F00000. Control (0x20): only bits 31:21 of the write.
- R5: A read of the timing offset 0x80 returns 0xFFFFFFFF, and so does a read of any offset that names no sub-register. Writes to the status word at offset 0x24 leave it unchanged.
- R6: When control bit 31 (global enable) changes from 0 to 1, status bit 31 clears. When it changes from 1 to 0, status bit 31 sets.
- R7: Whenever a control write changes control bit 30, status bit 30 takes the new value of that bit.
- R8: A write to the control word of bank i, at offset 0x40 + 4*i, stores the write AND 0xFFDEE001, and a read there returns the stored value.
- R9: A bank hits an address only when all of these hold: its bit 0 (valid) is set, control bit 31 is set, and its size code (bits 19:17) is not 7. When they hold, the bank covers 4 MiB shifted left by the size code, and it hits when the address bits above that size equal the same bits of the bank word masked by 0xFF800000.
- R10: `bank_sel` is one-hot on the lowest-numbered bank that hits, and all zero when no bank hits.
- R11: The ECC error status at offset 0x98 stores the write AND 0xFFF0F000. `ecc_irq` is high from the cycle after a write that leaves a nonzero value, and low from the cycle after a write that leaves zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | BUS_AW | Bus address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| phys_addr | input | 32 | Physical address to decode |
| bank_hit | output | NBANK | Per-bank hit flags |
| bank_sel | output | NBANK | One-hot select of the lowest hitting bank |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
The assertions check these on every cycle:
- the bank select is one-hot and a subset of the hit flags
- no bank hits while the global enable is clear
- each edge of the enable bit moves status bit 31 the way R6 sets out
- status writes are ignored
- the interrupt follows the ECC error status
- the read strobe follows read requests with one cycle of latency

The bench scenarios are needed for what a property cannot state compactly: the exact masked value each sub-register keeps, reset contents, the all-ones readback, and whether a given address falls inside a bank of a given size and base, including overlapping banks and the invalid size code.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;

   // sub-register offsets reached through the data port
   localparam logic [31:0] OFS_ERRSTAT0  = 32'h00;
   localparam logic [31:0] OFS_ERRSTAT1  = 32'h08;
   localparam logic [31:0] OFS_ERRADDR   = 32'h10;
   localparam logic [31:0] OFS_CTRL      = 32'h20;
   localparam logic [31:0] OFS_STAT      = 32'h24;
   localparam logic [31:0] OFS_REFRESH   = 32'h30;
   localparam logic [31:0] OFS_PWRTMR    = 32'h34;
   localparam logic [31:0] OFS_BANK0     = 32'h40;
   localparam logic [31:0] OFS_BANK_STEP = 32'h04;
   localparam logic [31:0] OFS_TIMING    = 32'h80;
   localparam logic [31:0] OFS_ECCCFG    = 32'h94;
   localparam logic [31:0] OFS_ECCERR    = 32'h98;

   // store masks
   localparam logic [31:0] MSK_CTRL    = 32'hFFE0_0000;
   localparam logic [31:0] MSK_REFRESH = 32'h3FF8_0000;
   localparam logic [31:0] MSK_PWRTMR  = 32'hF800_0000;
   localparam logic [31:0] FIX_PWRTMR  = 32'h07C0_0000;
   localparam logic [31:0] MSK_TIMING  = 32'h018F_C01F;
   localparam logic [31:0] MSK_ECCCFG  = 32'h00F0_0000;
   localparam logic [31:0] MSK_ECCERR  = 32'hFFF0_F000;
   localparam logic [31:0] MSK_BANK    = 32'hFFDE_E001;

   // reset values
   localparam logic [31:0] RST_CTRL    = 32'h0080_0000;
   localparam logic [31:0] RST_REFRESH = 32'h05F0_0000;
   localparam logic [31:0] RST_PWRTMR  = 32'h07C0_0000;
   localparam logic [31:0] RST_TIMING  = 32'h0085_4009;

   // control / status bit positions
   localparam int CTRL_EN_BIT  = 31;
   localparam int CTRL_AUX_BIT = 30;

   // decode granularity: smallest bank is 2**MIN_SHIFT bytes
   localparam int MIN_SHIFT = 22;
   localparam int BASE_LSB  = 23;

   // decode view of one bank control word
   typedef struct packed {
      logic       valid;
      logic [2:0] code;
      logic [8:0] base;
   } bank_view_t;

   function automatic bank_view_t view_of(input logic [31:0] cr);
      bank_view_t v;
      v.valid = cr[0];
      v.code  = cr[19:17];
      v.base  = cr[31:BASE_LSB];
      return v;
   endfunction

endpackage

// File: rtl/memcfg_port.sv
module memcfg_port #(
   parameter int              BUS_AW    = 10,
   parameter logic [BUS_AW-1:0] OFS_PORT  = 'h10,
   parameter logic [BUS_AW-1:0] DATA_PORT = 'h11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [BUS_AW-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   input  logic [31:0]       sub_rdata,
   output logic [31:0]       ofs_q,
   output logic              sub_wr,
   output logic              rd_valid,
   output logic [31:0]       rd_data
);

   logic hit_ofs, hit_data;
   logic [31:0] rd_next;

   assign hit_ofs  = (req_addr == OFS_PORT);
   assign hit_data = (req_addr == DATA_PORT);
   assign sub_wr   = req_valid && req_write && hit_data;

   always_comb begin
      if (hit_ofs)       rd_next = ofs_q;
      else if (hit_data) rd_next = sub_rdata;
      else               rd_next = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ofs_q    <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         if (req_valid && req_write && hit_ofs)
            ofs_q <= req_wdata;
         rd_valid <= req_valid && !req_write;
         if (req_valid && !req_write)
            rd_data <= rd_next;
      end
   end

endmodule

// File: rtl/memcfg_regs.sv
module memcfg_regs
   import memcfg_pkg::*;
#(
   parameter int NBANK           = 4,
   parameter bit TIMING_READBACK = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [31:0]                  ofs_i,
   input  logic                         wr_i,
   input  logic [31:0]                  wdata_i,
   output logic [31:0]                  rdata_o,
   output bank_view_t [NBANK-1:0]       bank_o,
   output logic                         en_o,
   output logic [31:0]                  stat_o,
   output logic [31:0]                  ecc_o,
   output logic                         irq_o
);

   logic [31:0] errs0_q, errs1_q, erraddr_q, ctrl_q, stat_q;
   logic [31:0] refr_q, pwr_q, ecccfg_q, eccerr_q;
   logic        irq_q;
   logic [31:0] ctrl_wv, eccerr_wv, timing_rd;
   logic [NBANK-1:0][31:0] cr_q;

   assign ctrl_wv   = wdata_i & MSK_CTRL;
   assign eccerr_wv = wdata_i & MSK_ECCERR;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         errs0_q   <= '0;
         errs1_q   <= '0;
         erraddr_q <= '0;
         ctrl_q    <= RST_CTRL;
         stat_q    <= '0;
         refr_q    <= RST_REFRESH;
         pwr_q     <= RST_PWRTMR;
         ecccfg_q  <= '0;
         eccerr_q  <= '0;
         irq_q     <= 1'b0;
      end else if (wr_i) begin
         case (ofs_i)
            OFS_ERRSTAT0: errs0_q   <= errs0_q & ~wdata_i;
            OFS_ERRSTAT1: errs1_q   <= errs1_q & ~wdata_i;
            OFS_ERRADDR:  erraddr_q <= wdata_i;
            OFS_CTRL: begin
               if (!ctrl_q[CTRL_EN_BIT] && ctrl_wv[CTRL_EN_BIT])
                  stat_q[CTRL_EN_BIT] <= 1'b0;
               else if (ctrl_q[CTRL_EN_BIT] && !ctrl_wv[CTRL_EN_BIT])
                  stat_q[CTRL_EN_BIT] <= 1'b1;
               if (ctrl_q[CTRL_AUX_BIT] != ctrl_wv[CTRL_AUX_BIT])
                  stat_q[CTRL_AUX_BIT] <= ctrl_wv[CTRL_AUX_BIT];
               ctrl_q <= ctrl_wv;
            end
            OFS_REFRESH:  refr_q   <= wdata_i & MSK_REFRESH;
            OFS_PWRTMR:   pwr_q    <= (wdata_i & MSK_PWRTMR) | FIX_PWRTMR;
            OFS_ECCCFG:   ecccfg_q <= wdata_i & MSK_ECCCFG;
            OFS_ECCERR: begin
               eccerr_q <= eccerr_wv;
               irq_q    <= (eccerr_wv != '0);
            end
            default: ;
         endcase
      end
   end

   // one control word per bank
   for (genvar i = 0; i < NBANK; i++) begin : g_bank
      localparam logic [31:0] MY_OFS = OFS_BANK0 + 32'(i) * OFS_BANK_STEP;
      logic [31:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q <= '0;
         else if (wr_i && ofs_i == MY_OFS)
            word_q <= wdata_i & MSK_BANK;
      end
      assign cr_q[i]   = word_q;
      assign bank_o[i] = view_of(word_q);
   end

   // timing word: write-only by default, optionally readable
   if (TIMING_READBACK) begin : g_tim_rb
      logic [31:0] tim_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            tim_q <= RST_TIMING;
         else if (wr_i && ofs_i == OFS_TIMING)
            tim_q <= wdata_i & MSK_TIMING;
      end
      assign timing_rd = tim_q;
   end else begin : g_tim_ones
      assign timing_rd = '1;
   end

   always_comb begin
      case (ofs_i)
         OFS_ERRSTAT0: rdata_o = errs0_q;
         OFS_ERRSTAT1: rdata_o = errs1_q;
         OFS_ERRADDR:  rdata_o = erraddr_q;
         OFS_CTRL:     rdata_o = ctrl_q;
         OFS_STAT:     rdata_o = stat_q;
         OFS_REFRESH:  rdata_o = refr_q;
         OFS_PWRTMR:   rdata_o = pwr_q;
         OFS_TIMING:   rdata_o = timing_rd;
         OFS_ECCCFG:   rdata_o = ecccfg_q;
         OFS_ECCERR:   rdata_o = eccerr_q;
         default:      rdata_o = '1;
      endcase
      for (int i = 0; i < NBANK; i++) begin
         if (ofs_i == OFS_BANK0 + 32'(i) * OFS_BANK_STEP)
            rdata_o = cr_q[i];
      end
   end

   assign en_o   = ctrl_q[CTRL_EN_BIT];
   assign stat_o = stat_q;
   assign ecc_o  = eccerr_q;
   assign irq_o  = irq_q;

endmodule

// File: rtl/memcfg_bank_match.sv
module memcfg_bank_match
   import memcfg_pkg::*;
(
   input  bank_view_t  view_i,
   input  logic        en_i,
   input  logic [31:0] addr_i,
   output logic        hit_o
);

   logic [5:0]  shamt;
   logic [31:0] keep_mask;
   logic [31:0] base_full;

   assign shamt     = 6'(MIN_SHIFT) + {3'b000, view_i.code};
   assign keep_mask = {32{1'b1}} << shamt;
   assign base_full = {view_i.base, {BASE_LSB{1'b0}}};
   assign hit_o     = en_i && view_i.valid && (view_i.code != 3'd7) &&
                      (((addr_i ^ base_full) & keep_mask) == '0);

endmodule

// File: rtl/memcfg_indirect_regs.sv
module memcfg_indirect_regs
   import memcfg_pkg::*;
#(
   parameter int                NBANK           = 4,
   parameter int                BUS_AW          = 10,
   parameter logic [BUS_AW-1:0] OFS_PORT        = 'h10,
   parameter logic [BUS_AW-1:0] DATA_PORT       = 'h11,
   parameter bit                TIMING_READBACK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [BUS_AW-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rd_valid,
   output logic [31:0]       rd_data,
   input  logic [31:0]       phys_addr,
   output logic [NBANK-1:0]  bank_hit,
   output logic [NBANK-1:0]  bank_sel,
   output logic              ecc_irq
);

   if (NBANK < 1 || NBANK > 4) begin : g_bad_nbank
      $error("memcfg_indirect_regs: NBANK must be 1..4");
   end
   if (OFS_PORT == DATA_PORT) begin : g_bad_ports
      $error("memcfg_indirect_regs: port addresses must differ");
   end

   logic [31:0]           ofs_q;
   logic                  sub_wr;
   logic [31:0]           sub_rdata;
   bank_view_t [NBANK-1:0] views;
   logic                  en_q;
   logic [31:0]           stat_q;
   logic [31:0]           ecc_q;

   memcfg_port #(
      .BUS_AW   (BUS_AW),
      .OFS_PORT (OFS_PORT),
      .DATA_PORT(DATA_PORT)
   ) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_write(req_write),
      .req_addr (req_addr),
      .req_wdata(req_wdata),
      .sub_rdata(sub_rdata),
      .ofs_q    (ofs_q),
      .sub_wr   (sub_wr),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   memcfg_regs #(
      .NBANK          (NBANK),
      .TIMING_READBACK(TIMING_READBACK)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .ofs_i  (ofs_q),
      .wr_i   (sub_wr),
      .wdata_i(req_wdata),
      .rdata_o(sub_rdata),
      .bank_o (views),
      .en_o   (en_q),
      .stat_o (stat_q),
      .ecc_o  (ecc_q),
      .irq_o  (ecc_irq)
   );

   for (genvar i = 0; i < NBANK; i++) begin : g_match
      memcfg_bank_match u_match (
         .view_i(views[i]),
         .en_i  (en_q),
         .addr_i(phys_addr),
         .hit_o (bank_hit[i])
      );
   end

   // lowest-numbered hitting bank wins
   assign bank_sel = bank_hit & ~(bank_hit - NBANK'(1));

endmodule

// File: rtl/memcfg_chk.sv
module memcfg_chk #(
   parameter int                NBANK     = 4,
   parameter int                BUS_AW    = 10,
   parameter logic [BUS_AW-1:0] DATA_PORT = 'h11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [BUS_AW-1:0] req_addr,
   input logic              rd_valid,
   input logic [NBANK-1:0]  bank_hit,
   input logic [NBANK-1:0]  bank_sel,
   input logic              ecc_irq,
   input logic [31:0]       ofs_q,
   input logic              en_q,
   input logic [31:0]       stat_q,
   input logic [31:0]       ecc_q
);

   logic stat_wr;
   assign stat_wr = req_valid && req_write && (req_addr == DATA_PORT) &&
                    (ofs_q == 32'h24);

   // R2
   rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rd_valid);
   // R2
   rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rd_valid);
   // R5
   stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> $stable(stat_q));
   // R6
   en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q) |-> !stat_q[31]);
   // R6
   en_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_q) |-> stat_q[31]);
   // R9
   no_hit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (bank_hit == '0));
   // R10
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_sel));
   // R10
   sel_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bank_sel & ~bank_hit) == '0) && ((bank_hit != '0) == (bank_sel != '0)));
   // R11
   irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_irq == (ecc_q != '0));

endmodule

bind memcfg_indirect_regs memcfg_chk #(
   .NBANK    (NBANK),
   .BUS_AW   (BUS_AW),
   .DATA_PORT(DATA_PORT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_write(req_write),
   .req_addr (req_addr),
   .rd_valid (rd_valid),
   .bank_hit (bank_hit),
   .bank_sel (bank_sel),
   .ecc_irq  (ecc_irq),
   .ofs_q    (ofs_q),
   .en_q     (en_q),
   .stat_q   (stat_q),
   .ecc_q    (ecc_q)
);

// File: tb/memcfg_indirect_regs_test.sv
module memcfg_indirect_regs_test;

   localparam int NB = 4;
   localparam int AW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0]   req_wdata = '0;
   logic          rd_valid;
   logic [31:0]   rd_data;
   logic [31:0]   phys_addr = '0;
   logic [NB-1:0] bank_hit, bank_sel;
   logic          ecc_irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   memcfg_indirect_regs #(.NBANK(NB), .BUS_AW(AW)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .phys_addr(phys_addr), .bank_hit(bank_hit),
      .bank_sel(bank_sel), .ecc_irq(ecc_irq)
   );

   always #5 clk = ~clk;

   // monitor: pops expected read data as the design returns it
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         n_tests++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R2: unexpected read data actual=%h expected=none", rd_data);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rd_data !== e) begin
               n_fail++;
               $display("FAIL %s: read actual=%h expected=%h", t, rd_data, e);
            end
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic sub_write(input logic [31:0] ofs, input logic [31:0] d);
      bus_write(AW'('h10), ofs);
      bus_write(AW'('h11), d);
   endtask

   task automatic sub_read(input logic [31:0] ofs, input logic [31:0] exp, input string tag);
      bus_write(AW'('h10), ofs);
      bus_read(AW'('h11), exp, tag);
   endtask

   task automatic probe(input logic [31:0] a, input logic [NB-1:0] eh,
                        input logic [NB-1:0] es, input string tag);
      @(negedge clk);
      phys_addr = a;
      #1;
      check({tag, " hit"}, 32'(bank_hit), 32'(eh));
      check({tag, " sel"}, 32'(bank_sel), 32'(es));
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_read(AW'('h10), 32'h0, "R1 offset latch");
      sub_read(32'h20, 32'h0080_0000, "R1 control");
      sub_read(32'h34, 32'h07C0_0000, "R1 power timer");
      sub_read(32'h30, 32'h05F0_0000, "R1 refresh timer");
      sub_read(32'h24, 32'h0, "R1 status");
      sub_read(32'h98, 32'h0, "R1 ecc status");
      sub_read(32'h94, 32'h0, "R1 ecc config");
      sub_read(32'h40, 32'h0, "R1 bank0");
      sub_read(32'h10, 32'h0, "R1 error address");
      check("R1 irq", 32'(ecc_irq), 32'h0);
      probe(32'h0000_0000, 4'b0000, 4'b0000, "R1 decode");

      // R2 indirect access
      bus_write(AW'('h10), 32'h0000_1234);
      bus_read(AW'('h10), 32'h0000_1234, "R2 offset readback");
      bus_read(AW'('h55), 32'h0, "R2 other bus address");
      bus_write(AW'('h55), 32'hFFFF_FFFF);
      bus_read(AW'('h11), 32'hFFFF_FFFF, "R2 data port unknown offset");

      // R3 error status / address
      sub_write(32'h00, 32'hFFFF_FFFF);
      sub_read(32'h00, 32'h0, "R3 errstat0 w1c");
      sub_write(32'h08, 32'hA5A5_A5A5);
      sub_read(32'h08, 32'h0, "R3 errstat1 w1c");
      sub_write(32'h10, 32'hDEAD_BEEF);
      sub_read(32'h10, 32'hDEAD_BEEF, "R3 error address");

      // R4 masked stores
      sub_write(32'h30, 32'hFFFF_FFFF);
      sub_read(32'h30, 32'h3FF8_0000, "R4 refresh mask");
      sub_write(32'h34, 32'hFFFF_FFFF);
      sub_read(32'h34, 32'hFFC0_0000, "R4 power all ones");
      sub_write(32'h34, 32'h0);
      sub_read(32'h34, 32'h07C0_0000, "R4 power zero");
      sub_write(32'h94, 32'hFFFF_FFFF);
      sub_read(32'h94, 32'h00F0_0000, "R4 ecc config mask");
      sub_write(32'h20, 32'h00BF_FFFF);
      sub_read(32'h20, 32'h00A0_0000, "R4 control mask");

      // R5 timing / unknown / status read-only
      sub_write(32'h80, 32'h1234_5678);
      sub_read(32'h80, 32'hFFFF_FFFF, "R5 timing reads ones");
      sub_read(32'h50, 32'hFFFF_FFFF, "R5 unknown offset");
      sub_write(32'h24, 32'hFFFF_FFFF);
      sub_read(32'h24, 32'h0, "R5 status ignores write");

      // R6 / R7 enable and aux edges
      sub_write(32'h20, 32'h8000_0000);
      sub_read(32'h24, 32'h0, "R6 rise keeps bit31 clear");
      sub_write(32'h20, 32'h0);
      sub_read(32'h24, 32'h8000_0000, "R6 fall sets bit31");
      sub_write(32'h20, 32'hC000_0000);
      sub_read(32'h24, 32'h4000_0000, "R6 R7 rise clears 31, sets 30");
      sub_write(32'h20, 32'h8000_0000);
      sub_read(32'h24, 32'h0, "R7 bit30 fall copied");

      // R8 bank word mask
      sub_write(32'h40, 32'hFFFF_FFFF);
      sub_read(32'h40, 32'hFFDE_E001, "R8 bank0 mask");
      probe(32'hFF80_0000, 4'b0000, 4'b0000, "R9 code 7 invalid");

      // R9 / R10 decode
      sub_write(32'h40, 32'h0000_0001);
      sub_write(32'h44, 32'h0082_0001);
      sub_write(32'h48, 32'h1004_0001);
      sub_write(32'h4C, 32'h1000_0001);
      sub_read(32'h4C, 32'h1000_0001, "R8 bank3 readback");
      probe(32'h003F_FFFC, 4'b0001, 4'b0001, "R9 bank0 4MiB");
      probe(32'h0040_0000, 4'b0000, 4'b0000, "R9 gap above bank0");
      probe(32'h00FF_FFFF, 4'b0010, 4'b0010, "R9 bank1 8MiB top");
      probe(32'h1000_0000, 4'b1100, 4'b0100, "R10 overlap lowest wins");
      probe(32'h1040_0000, 4'b0100, 4'b0100, "R9 bank2 beyond bank3");
      probe(32'h1100_0000, 4'b0000, 4'b0000, "R9 above bank2");
      sub_write(32'h20, 32'h0);
      probe(32'h1000_0000, 4'b0000, 4'b0000, "R9 global disable");
      sub_write(32'h20, 32'h8000_0000);
      probe(32'h1000_0000, 4'b1100, 4'b0100, "R9 re-enable");
      sub_write(32'h44, 32'h0082_0000);
      probe(32'h00FF_FFFF, 4'b0000, 4'b0000, "R9 valid bit clear");

      // R11 ecc error status and interrupt
      sub_write(32'h98, 32'hFFFF_FFFF);
      check("R11 irq set", 32'(ecc_irq), 32'h1);
      sub_read(32'h98, 32'hFFF0_F000, "R11 ecc status mask");
      sub_write(32'h98, 32'h000F_0FFF);
      check("R11 irq clear on masked zero", 32'(ecc_irq), 32'h0);
      sub_read(32'h98, 32'h0, "R11 ecc status zero");
      sub_write(32'h98, 32'h0000_1000);
      check("R11 irq set again", 32'(ecc_irq), 32'h1);

      repeat (3) @(negedge clk);
      n_tests++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R2: pending reads actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule